// File: doc/BRIEF.md
# IrDA SIR Pulse Codec

This block sits between a standard UART and an infrared transceiver. On the way out it takes the UART serial output and reshapes each bit cell. A zero becomes a short high pulse, and a one leaves the optical line dark. On the way in it watches the receive pin from the transceiver for pulse edges. It widens each edge into a full-width low bit cell, so an ordinary UART receiver can sample the line as plain NRZ data.

All timing counts in ticks of a 16x oversampling clock enable, `os_tick`, so a bit cell is 16 ticks long. The encoder finds bit boundaries from changes in the UART output. The decoder rebuilds the data line on its own, so the two directions run full duplex. When `ir_en` is low the block becomes a pair of wires: the UART output drives the transmit pin directly, and the raw receive pin drives the UART input. The asynchronous receive pin passes through a two-flop synchronizer before it is decoded.

Top module: `irda_sir_codec`

## Requirements
- R1: During reset and after its release, with `ir_en` high and no activity, `ir_tx` is 0 and `uart_rxd` is 1.
- R2: With `ir_en` high, the tick that captures a new `uart_txd` level starts a bit cell, and that tick is numbered 0. A zero bit drives `ir_tx` high after ticks 6, 7 and 8 of the cell, which gives exactly three ticks high. It is low after every other tick.
- R3: With `ir_en` high, a one bit keeps `ir_tx` low for all 16 ticks of its cell.
- R4: Back-to-back zero bits of 16 ticks each produce a separate three-tick pulse in each cell, with no change of `uart_txd` between them.
- R5: `ir_rx` is resynchronized over two clocks and sampled on ticks. A low-to-high change seen at a tick drives the decoded output low after that tick. It stays low for 16 ticks and then returns high.
- R6: A new rising edge that arrives while the output is still held low restarts the 16-tick hold. Pulses in consecutive bit cells therefore give one unbroken low level.
- R7: The length of a received pulse does not extend the hold. An input that stays high longer than 16 ticks still gives only 16 ticks of low output.
- R8: With `ir_en` low, `ir_tx` equals `uart_txd` and `uart_rxd` equals `ir_rx` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| ir_en | input | 1 | 1 = infrared coding, 0 = direct wire mode |
| uart_txd | input | 1 | Serial output of the UART transmitter |
| ir_tx | output | 1 | Drive to the infrared emitter, idles low |
| ir_rx | input | 1 | Pulse input from the infrared detector, asynchronous |
| uart_rxd | output | 1 | Rebuilt serial line for the UART receiver, idles high |

## Verification
Two things can land on the same tick in the decoder: the hold from the previous pulse expires, and the rising edge of the next pulse arrives and reloads it. The bench provokes this with zero bits in consecutive cells, first in a directed pair and then inside random byte frames. It judges the result per tick against a bench model of the hold, which requires an unbroken low level across the cell boundary. The encoder's bit boundary and its phase wrap share a tick in the same way. The bench covers that case with runs of consecutive transmitted zeros, and each cell is checked tick by tick for its own pulse.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

  // Operating mode selected by the ir_en pin.
  typedef enum logic {
    SIR_WIRE = 1'b0,
    SIR_IR   = 1'b1
  } sir_mode_e;

  // Default timing, counted in oversampling ticks.
  localparam int unsigned SIR_OVERSAMPLE  = 16;
  localparam int unsigned SIR_PULSE_START = 6;
  localparam int unsigned SIR_PULSE_LEN   = 3;
  localparam int unsigned SIR_STRETCH     = 16;
  localparam int unsigned SIR_SYNC_STAGES = 2;

endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= RST_VAL;
        else        sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder #(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned PULSE_START = 6,
  parameter int unsigned PULSE_LEN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txd,
  output logic pulse_o
);

  localparam int unsigned PW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [PW-1:0] PH_LAST  = PW'(OVERSAMPLE - 1);
  localparam logic [PW-1:0] PH_FIRST = PW'(PULSE_START);
  localparam logic [PW-1:0] PH_END   = PW'(PULSE_START + PULSE_LEN - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          level_q, level_d;
  logic          pulse_q, pulse_d;

  // Next state: a level change restarts the cell, otherwise the phase wraps.
  always_comb begin
    phase_d = phase_q;
    level_d = level_q;
    pulse_d = pulse_q;
    if (tick) begin
      level_d = txd;
      if (txd != level_q) begin
        phase_d = '0;
      end else if (phase_q == PH_LAST) begin
        phase_d = '0;
      end else begin
        phase_d = phase_q + 1'b1;
      end
      pulse_d = !txd && (phase_d >= PH_FIRST) && (phase_d <= PH_END);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      level_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      level_q <= level_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/irda_sir_decoder.sv
module irda_sir_decoder #(
  parameter int unsigned STRETCH     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ir_in,
  output logic rxd_o
);

  localparam int unsigned CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(STRETCH);

  logic          ir_s;
  logic          prev_q, prev_d;
  logic [CW-1:0] hold_q, hold_d;

  sir_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ir_in),
    .q     (ir_s)
  );

  // Next state: a rising edge (re)loads the hold, otherwise it drains per tick.
  always_comb begin
    prev_d = prev_q;
    hold_d = hold_q;
    if (tick) begin
      prev_d = ir_s;
      if (ir_s && !prev_q) begin
        hold_d = CNT_LOAD;
      end else if (hold_q != '0) begin
        hold_d = hold_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= prev_d;
      hold_q <= hold_d;
    end
  end

  assign rxd_o = (hold_q == '0);

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
  import irda_sir_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = SIR_OVERSAMPLE,
  parameter int unsigned PULSE_START = SIR_PULSE_START,
  parameter int unsigned PULSE_LEN   = SIR_PULSE_LEN,
  parameter int unsigned STRETCH     = SIR_STRETCH,
  parameter int unsigned SYNC_STAGES = SIR_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic ir_en,
  input  logic uart_txd,
  output logic ir_tx,
  input  logic ir_rx,
  output logic uart_rxd
);

  logic      core_rst_n;
  logic      enc_pulse;
  logic      dec_rxd;
  sir_mode_e mode;

  // Reset asserts at once and is released on a clock edge.
  sir_sync #(
    .STAGES  (2),
    .RST_VAL (1'b0)
  ) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (core_rst_n)
  );

  irda_sir_encoder #(
    .OVERSAMPLE  (OVERSAMPLE),
    .PULSE_START (PULSE_START),
    .PULSE_LEN   (PULSE_LEN)
  ) u_enc (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (os_tick),
    .txd     (uart_txd),
    .pulse_o (enc_pulse)
  );

  irda_sir_decoder #(
    .STRETCH     (STRETCH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dec (
    .clk   (clk),
    .rst_n (core_rst_n),
    .tick  (os_tick),
    .ir_in (ir_rx),
    .rxd_o (dec_rxd)
  );

  assign mode = sir_mode_e'(ir_en);

  always_comb begin
    unique case (mode)
      SIR_IR: begin
        ir_tx    = enc_pulse;
        uart_rxd = dec_rxd;
      end
      default: begin
        ir_tx    = uart_txd;
        uart_rxd = ir_rx;
      end
    endcase
  end

endmodule

// File: rtl/irda_sir_checker.sv
module irda_sir_checker #(
  parameter int unsigned PULSE_LEN = 3,
  parameter int unsigned STRETCH   = 16
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic ir_en,
  input logic uart_txd,
  input logic ir_tx,
  input logic ir_rx,
  input logic uart_rxd
);

  localparam int unsigned HW = $clog2(PULSE_LEN + 1) + 1;
  localparam int unsigned LW = $clog2(STRETCH + 1) + 1;

  logic [HW-1:0] high_ticks;
  logic [LW-1:0] low_ticks;
  logic          low_valid;

  // Ticks seen while the emitter drive is high in infrared mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_ticks <= '0;
    end else if (!ir_en || !ir_tx) begin
      high_ticks <= '0;
    end else if (tick && (high_ticks != '1)) begin
      high_ticks <= high_ticks + 1'b1;
    end
  end

  // Ticks seen while the rebuilt line is low, counted only from a high start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_ticks <= '0;
      low_valid <= 1'b0;
    end else if (!ir_en) begin
      low_ticks <= '0;
      low_valid <= 1'b0;
    end else if (uart_rxd) begin
      low_ticks <= '0;
      low_valid <= 1'b1;
    end else if (tick && (low_ticks != '1)) begin
      low_ticks <= low_ticks + 1'b1;
    end
  end

  // R2: a pulse never spans more than PULSE_LEN ticks.
  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && ir_tx && tick) |-> (high_ticks < HW'(PULSE_LEN)));

  // R2: the emitter drive only moves after a tick edge in infrared mode.
  p_tx_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && $past(ir_en) && !$past(tick)) |-> $stable(ir_tx));

  // R5: once the rebuilt line drops, it stays low for at least STRETCH ticks.
  p_hold_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(uart_rxd) && ir_en && $past(ir_en) && low_valid) |-> (low_ticks >= LW'(STRETCH)));

  // R8: wire mode passes the transmit line straight through.
  p_wire_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_en |-> (ir_tx == uart_txd));

  // R8: wire mode passes the receive line straight through.
  p_wire_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_en |-> (uart_rxd == ir_rx));

endmodule

bind irda_sir_codec irda_sir_checker #(
  .PULSE_LEN (PULSE_LEN),
  .STRETCH   (STRETCH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (os_tick),
  .ir_en    (ir_en),
  .uart_txd (uart_txd),
  .ir_tx    (ir_tx),
  .ir_rx    (ir_rx),
  .uart_rxd (uart_rxd)
);

// File: tb/irda_sir_codec_tb.sv
module irda_sir_codec_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P_FIRST    = 6;
  localparam int P_LAST     = 8;
  localparam int HOLD       = 16;

  logic clk;
  logic rst_n;
  logic os_tick;
  logic ir_en;
  logic uart_txd;
  logic ir_tx;
  logic ir_rx;
  logic uart_rxd;

  int n_cmp;
  int n_bad;
  int m_hold;
  logic m_prev;
  logic last_tx;
  logic last_rx;

  irda_sir_codec u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .ir_en    (ir_en),
    .uart_txd (uart_txd),
    .ir_tx    (ir_tx),
    .ir_rx    (ir_rx),
    .uart_rxd (uart_rxd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic in_pulse(input int s);
    return (s >= P_FIRST) && (s <= P_LAST);
  endfunction

  // Expected rebuilt line: a rising edge at a tick loads a 16-tick hold.
  function automatic logic rx_model(input logic pin);
    if (pin && !m_prev) m_hold = HOLD;
    else if (m_hold > 0) m_hold--;
    m_prev = pin;
    return (m_hold == 0);
  endfunction

  // One tick slot: inputs set, two clocks for the synchronizer, tick, compare.
  task automatic slot(input logic txd, input logic pin, input logic exp_tx,
                      input string tag_tx, input string tag_rx);
    logic exp_rx;
    @(negedge clk);
    uart_txd = txd;
    ir_rx    = pin;
    os_tick  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
    exp_rx = rx_model(pin);
    chk(tag_tx, ir_tx, exp_tx);
    chk(tag_rx, uart_rxd, exp_rx);
  endtask

  task automatic send_bit(input logic tb_bit, input logic rb_bit);
    string ttag;
    string rtag;
    ttag = tb_bit ? "R3" : ((last_tx == 1'b0) ? "R4" : "R2");
    rtag = (rb_bit == 1'b0 && last_rx == 1'b0) ? "R6" : "R5";
    for (int s = 0; s < 16; s++) begin
      slot(tb_bit, !rb_bit && in_pulse(s), !tb_bit && in_pulse(s), ttag, rtag);
    end
    last_tx = tb_bit;
    last_rx = rb_bit;
  endtask

  task automatic send_frame(input logic [7:0] tb, input logic [7:0] rb);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(tb[i], rb[i]);
    send_bit(1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1: watchdog expired, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp    = 0;
    n_bad    = 0;
    m_hold   = 0;
    m_prev   = 1'b0;
    last_tx  = 1'b1;
    last_rx  = 1'b1;
    rst_n    = 1'b0;
    os_tick  = 1'b0;
    ir_en    = 1'b1;
    uart_txd = 1'b1;
    ir_rx    = 1'b0;
    void'($urandom(32'h5a17));

    // R1: idle levels in reset and after release.
    repeat (3) @(negedge clk);
    chk("R1", ir_tx, 1'b0);
    chk("R1", uart_rxd, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", ir_tx, 1'b0);
    chk("R1", uart_rxd, 1'b1);

    // Idle, then single and back-to-back zeros in both directions (R2 to R6).
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b1);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b1);

    // R7: a long high input gives only one 16-tick hold.
    for (int s = 0; s < 32; s++) begin
      slot(1'b1, (s < 24), 1'b0, "R3", "R7");
    end
    send_bit(1'b1, 1'b1);

    // R8: wire mode, no ticks, checks in the same cycle.
    @(negedge clk);
    ir_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      uart_txd = 1'($urandom);
      ir_rx    = 1'($urandom);
      #1;
      chk("R8", ir_tx, uart_txd);
      chk("R8", uart_rxd, ir_rx);
    end
    @(negedge clk);
    uart_txd = 1'b1;
    ir_rx    = 1'b0;
    repeat (3) @(negedge clk);
    ir_en = 1'b1;
    send_bit(1'b1, 1'b1);

    // Random full-duplex byte frames (R2 to R6).
    for (int f = 0; f < 24; f++) begin
      send_frame(8'($urandom), 8'($urandom));
      if (($urandom % 3) == 0) send_bit(1'b1, 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule